// File: doc/BRIEF.md
# NAND Flash Operation Sequencer

This block carries out one complete NAND flash operation on its own once it has been handed a description of that operation. The description consists of a column address, a row address, a byte count, three command opcodes and a 15-bit enable word. Each enable bit switches one kind of bus cycle on or off. After a start pulse, the sequencer latches the description and drives the flash pins (chip enable, command latch, address latch, write strobe, read strobe and an 8-bit data bus). It also watches the ready/busy line and raises a sticky completion flag when it has finished.

Enabled cycles always run in one hardware order, and cycles that are not enabled are skipped. As a result, a single description covers many operations: page read, page program, erase, status poll, identification read and bare commands. Payload bytes move between the flash and a word-wide page buffer. The host fills and drains that buffer through a separate port. Inside each 32-bit word the buffer holds flash bytes in big-endian order.

Top module: `nand_seq`

## Requirements
- R1: While reset is high and after it is released, ce_n, we_n and re_n are high, cle, ale, io_oe and done are low, and busy is low.
- R2: Enabled cycles run in descending enable-bit order: bit 14 cmd1, bits 13..9 address, bit 8 write data, bit 7 cmd2, bit 6 ready/busy wait, bit 5 read data, bit 4 cmd3, bit 3 status, bit 2 ID. Disabled cycles are skipped. Each command byte is one WE# pulse with CLE high, each address byte is one WE# pulse with ALE high, and CLE and ALE are never high together.
- R3: Address bits map to fixed bytes: bit 13 sends col_addr[7:0], bit 12 col_addr[15:8], bit 11 row_addr[7:0], bit 10 row_addr[15:8] and bit 9 row_addr[23:16]. This holds for any subset of these bits.
- R4: Bit 8 sends xfer_len bytes with CLE and ALE low. Byte b comes from buffer word b/4, bits [31-8*(b%4) -: 8].
- R5: Bit 5 reads xfer_len bytes. Each byte is captured from io_in when RE# rises and stored as buffer byte 0, 1, ... using the big-endian lane mapping of R4. io_oe is low while RE# is low.
- R6: Bit 6 waits T_WB clocks, then holds the sequence until rb_n (1 = ready) is seen high. No strobe occurs while rb_n is low.
- R7: Bit 3 reads one status byte into buffer byte 0. Bit 2 reads ID_LEN identification bytes into buffer bytes 0 upward.
- R8: done rises after the last enabled cycle and stays high until done_clr is pulsed. An accepted start clears it. An enable word with no cycle bits sets done without any bus activity.
- R9: A start pulse while busy is high is ignored. The running operation continues unchanged and no extra cycles follow it.
- R10: Every WE# or RE# low pulse lasts exactly T_PULSE clocks. For command and address cycles, CLE or ALE rises exactly T_SETUP clocks before WE# falls.
- R11: ce_n is low from an accepted start until done rises, including during the ready/busy wait.
- R12: A data phase enabled with xfer_len equal to 0 produces no strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, sampled when idle |
| done_clr | input | 1 | Clears the done flag |
| code | input | 15 | Cycle enable word, bits 14..2 used |
| col_addr | input | 16 | Column address, two bytes |
| row_addr | input | 24 | Row address, three bytes |
| xfer_len | input | LEN_W | Data phase byte count |
| opc1 | input | 8 | First command opcode |
| opc2 | input | 8 | Second command opcode |
| opc3 | input | 8 | Third command opcode |
| done | output | 1 | Sticky completion flag |
| busy | output | 1 | Operation in progress |
| buf_we | input | 1 | Host buffer word write enable |
| buf_waddr | input | AW | Host buffer write word address |
| buf_wdata | input | 32 | Host buffer write data |
| buf_raddr | input | AW | Host buffer read word address |
| buf_rdata | output | 32 | Host buffer read data, one clock latency |
| ce_n | output | 1 | Flash chip enable, active low |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| we_n | output | 1 | Write strobe, active low |
| re_n | output | 1 | Read strobe, active low |
| io_out | output | 8 | Data bus driven to the flash |
| io_oe | output | 1 | Data bus output enable |
| io_in | input | 8 | Data bus from the flash |
| rb_n | input | 1 | Ready/busy from the flash, 1 = ready |

## Verification
The hardest situation to reach from the ports is the one where a start pulse arrives while the sequencer is parked in its ready/busy wait. In that state no bus strobe is active, so the pulse could corrupt the latched description or restart the sequence without any visible sign on the pins. To reach it, the bench's flash model pulls rb_n low the moment it sees the second command opcode on the bus. The model then keeps rb_n low for a fixed number of clocks. During that window the bench pulses start with a different description, then checks that only the original bytes reach the bus, that no strobe fired while the line was busy, and that chip enable stayed low throughout.

// File: rtl/nseq_pkg.sv
package nseq_pkg;

    // Kind of a single bus cycle as seen by the strobe timer
    typedef enum logic [1:0] {
        K_CMD  = 2'd0,
        K_ADDR = 2'd1,
        K_WR   = 2'd2,
        K_RD   = 2'd3
    } cyc_kind_t;

    // Enable-word bit positions; the order of service is descending
    localparam logic [3:0] B_CMD1 = 4'd14;
    localparam logic [3:0] B_CA1  = 4'd13;
    localparam logic [3:0] B_CA2  = 4'd12;
    localparam logic [3:0] B_RA1  = 4'd11;
    localparam logic [3:0] B_RA2  = 4'd10;
    localparam logic [3:0] B_RA3  = 4'd9;
    localparam logic [3:0] B_WDAT = 4'd8;
    localparam logic [3:0] B_CMD2 = 4'd7;
    localparam logic [3:0] B_RB   = 4'd6;
    localparam logic [3:0] B_RDAT = 4'd5;
    localparam logic [3:0] B_CMD3 = 4'd4;
    localparam logic [3:0] B_STAT = 4'd3;
    localparam logic [3:0] B_ID   = 4'd2;

    localparam int          CODE_W    = 15;
    localparam logic [14:0] CODE_MASK = 15'h7FFC;

    // Latched operation description
    typedef struct packed {
        logic [15:0] col;
        logic [23:0] row;
        logic [7:0]  op1;
        logic [7:0]  op2;
        logic [7:0]  op3;
    } op_desc_t;

    function automatic cyc_kind_t kind_of(input logic [3:0] b);
        cyc_kind_t k;
        case (b)
            B_CMD1, B_CMD2, B_CMD3:             k = K_CMD;
            B_CA1, B_CA2, B_RA1, B_RA2, B_RA3:  k = K_ADDR;
            B_WDAT:                             k = K_WR;
            default:                            k = K_RD;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/nseq_phase_pick.sv
module nseq_phase_pick #(
    parameter int W  = 15,
    parameter int LO = 2
) (
    input  logic [W-1:0] pend,
    output logic         any,
    output logic [3:0]   idx
);
    // Highest pending bit wins: later loop iterations override earlier ones
    always_comb begin
        any = 1'b0;
        idx = 4'd0;
        for (int i = LO; i < W; i++) begin
            if (pend[i]) begin
                any = 1'b1;
                idx = 4'(i);
            end
        end
    end
endmodule

// File: rtl/nseq_bus_timer.sv
module nseq_bus_timer
    import nseq_pkg::*;
#(
    parameter int T_SETUP = 2,
    parameter int T_PULSE = 3,
    parameter int T_HOLD  = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       go,
    input  cyc_kind_t  kind,
    input  logic [7:0] byte_in,
    input  logic [7:0] io_in,
    output logic       cle,
    output logic       ale,
    output logic       we_n,
    output logic       re_n,
    output logic [7:0] io_out,
    output logic       io_oe,
    output logic       done,
    output logic       rd_vld,
    output logic [7:0] rd_byte
);
    localparam int TMAX = (T_SETUP > T_PULSE) ? ((T_SETUP > T_HOLD) ? T_SETUP : T_HOLD)
                                              : ((T_PULSE > T_HOLD) ? T_PULSE : T_HOLD);
    localparam int CW = $clog2(TMAX + 1);
    localparam logic [CW-1:0] SET_LAST = CW'(T_SETUP - 1);
    localparam logic [CW-1:0] PUL_LAST = CW'(T_PULSE - 1);
    localparam logic [CW-1:0] HLD_LAST = CW'(T_HOLD - 1);

    typedef enum logic [1:0] {T_IDLE, T_SET, T_PUL, T_HLD} tst_t;

    tst_t          st;
    logic [CW-1:0] cnt;
    cyc_kind_t     kq;
    logic [7:0]    bq;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= T_IDLE;
            cnt     <= '0;
            kq      <= K_CMD;
            bq      <= 8'h00;
            rd_vld  <= 1'b0;
            rd_byte <= 8'h00;
        end else begin
            rd_vld <= 1'b0;
            case (st)
                T_IDLE: if (go) begin
                    st  <= T_SET;
                    cnt <= '0;
                    kq  <= kind;
                    bq  <= byte_in;
                end
                T_SET: if (cnt == SET_LAST) begin
                    st  <= T_PUL;
                    cnt <= '0;
                end else cnt <= cnt + 1'b1;
                T_PUL: if (cnt == PUL_LAST) begin
                    st  <= T_HLD;
                    cnt <= '0;
                    if (kq == K_RD) begin
                        rd_byte <= io_in;
                        rd_vld  <= 1'b1;
                    end
                end else cnt <= cnt + 1'b1;
                T_HLD: if (cnt == HLD_LAST) begin
                    st  <= T_IDLE;
                    cnt <= '0;
                end else cnt <= cnt + 1'b1;
                default: st <= T_IDLE;
            endcase
        end
    end

    logic act;
    assign act    = (st != T_IDLE);
    assign cle    = act && (kq == K_CMD);
    assign ale    = act && (kq == K_ADDR);
    assign we_n   = !((st == T_PUL) && (kq != K_RD));
    assign re_n   = !((st == T_PUL) && (kq == K_RD));
    assign io_oe  = act && (kq != K_RD);
    assign io_out = io_oe ? bq : 8'h00;
    assign done   = (st == T_HLD) && (cnt == HLD_LAST);

    // R2: command and address latches are exclusive
    p_latch_excl_r2: assert property (@(posedge clk) disable iff (rst)
        !(cle && ale));

    // R10: only one strobe at a time
    p_strobe_excl_r10: assert property (@(posedge clk) disable iff (rst)
        !(!we_n && !re_n));

    // R10: latches and bus already settled when the write strobe falls
    p_setup_stable_r10: assert property (@(posedge clk) disable iff (rst)
        $fell(we_n) |-> ($stable(cle) && $stable(ale) && $stable(io_out)));

    // R5: bus released while reading
    p_rd_release_r5: assert property (@(posedge clk) disable iff (rst)
        !re_n |-> !io_oe);
endmodule

// File: rtl/nseq_page_buf.sv
module nseq_page_buf #(
    parameter int BYTES = 2112,
    parameter int IW    = 12,
    localparam int WORDS = (BYTES + 3) / 4,
    localparam int AW    = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          h_we,
    input  logic [AW-1:0] h_waddr,
    input  logic [31:0]   h_wdata,
    input  logic [AW-1:0] h_raddr,
    output logic [31:0]   h_rdata,
    input  logic          s_we,
    input  logic [IW-1:0] s_idx,
    input  logic [7:0]    s_wbyte,
    output logic [7:0]    s_rbyte
);
    logic [31:0]   mem [WORDS];
    logic [AW-1:0] s_word;
    logic [4:0]    s_sh;

    // Big-endian lane: byte 0 of a word sits in bits [31:24]
    assign s_word  = AW'(s_idx >> 2);
    assign s_sh    = {~s_idx[1:0], 3'b000};
    assign s_rbyte = mem[s_word][s_sh +: 8];

    always_ff @(posedge clk) begin
        if (h_we)
            mem[h_waddr] <= h_wdata;
        if (s_we)
            mem[s_word][s_sh +: 8] <= s_wbyte;
        h_rdata <= mem[h_raddr];
    end
endmodule

// File: rtl/nand_seq.sv
module nand_seq
    import nseq_pkg::*;
#(
    parameter int BUF_BYTES = 2112,
    parameter int T_SETUP   = 2,
    parameter int T_PULSE   = 3,
    parameter int T_HOLD    = 2,
    parameter int T_WB      = 4,
    parameter int ID_LEN    = 5,
    localparam int LEN_W    = $clog2(BUF_BYTES + 1),
    localparam int WORDS    = (BUF_BYTES + 3) / 4,
    localparam int AW       = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             done_clr,
    input  logic [14:0]      code,
    input  logic [15:0]      col_addr,
    input  logic [23:0]      row_addr,
    input  logic [LEN_W-1:0] xfer_len,
    input  logic [7:0]       opc1,
    input  logic [7:0]       opc2,
    input  logic [7:0]       opc3,
    output logic             done,
    output logic             busy,
    input  logic             buf_we,
    input  logic [AW-1:0]    buf_waddr,
    input  logic [31:0]      buf_wdata,
    input  logic [AW-1:0]    buf_raddr,
    output logic [31:0]      buf_rdata,
    output logic             ce_n,
    output logic             cle,
    output logic             ale,
    output logic             we_n,
    output logic             re_n,
    output logic [7:0]       io_out,
    output logic             io_oe,
    input  logic [7:0]       io_in,
    input  logic             rb_n
);
    localparam int WBW = $clog2(T_WB + 1);

    typedef enum logic [1:0] {S_IDLE, S_PICK, S_BYTE, S_RB} st_t;

    st_t              st;
    logic [14:0]      pend;
    op_desc_t         d;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] cnt;
    logic [LEN_W-1:0] cur_total;
    logic [3:0]       cur;
    logic [WBW-1:0]   wb_cnt;
    logic [1:0]       rb_sync;
    logic             done_q;
    logic             ce_q;

    logic       any;
    logic [3:0] idx;
    logic       zero_skip;
    logic       go;
    logic [7:0] tx_byte;
    logic [7:0] buf_rbyte;
    logic       tmr_done;
    logic       rd_vld;
    logic [7:0] rd_byte;

    nseq_phase_pick #(.W(CODE_W), .LO(2)) u_pick (
        .pend (pend),
        .any  (any),
        .idx  (idx)
    );

    // Byte offered to the timer for the phase about to start
    always_comb begin
        case (idx)
            B_CMD1:  tx_byte = d.op1;
            B_CMD2:  tx_byte = d.op2;
            B_CMD3:  tx_byte = d.op3;
            B_CA1:   tx_byte = d.col[7:0];
            B_CA2:   tx_byte = d.col[15:8];
            B_RA1:   tx_byte = d.row[7:0];
            B_RA2:   tx_byte = d.row[15:8];
            B_RA3:   tx_byte = d.row[23:16];
            B_WDAT:  tx_byte = buf_rbyte;
            default: tx_byte = 8'h00;
        endcase
    end

    // Number of bus bytes the current phase moves
    always_comb begin
        case (cur)
            B_WDAT, B_RDAT: cur_total = len_q;
            B_ID:           cur_total = LEN_W'(ID_LEN);
            default:        cur_total = LEN_W'(1);
        endcase
    end

    assign zero_skip = ((idx == B_WDAT) || (idx == B_RDAT)) && (len_q == '0);
    assign go        = (st == S_PICK) && any && (idx != B_RB) && !zero_skip;

    always_ff @(posedge clk) begin
        if (rst) rb_sync <= 2'b11;
        else     rb_sync <= {rb_sync[0], rb_n};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= S_IDLE;
            pend   <= '0;
            d      <= '0;
            len_q  <= '0;
            cnt    <= '0;
            cur    <= 4'd0;
            wb_cnt <= '0;
            done_q <= 1'b0;
            ce_q   <= 1'b1;
        end else begin
            if (done_clr) done_q <= 1'b0;
            case (st)
                S_IDLE: if (start) begin
                    pend   <= code & CODE_MASK;
                    d      <= '{col: col_addr, row: row_addr,
                                op1: opc1, op2: opc2, op3: opc3};
                    len_q  <= xfer_len;
                    cnt    <= '0;
                    done_q <= 1'b0;
                    ce_q   <= 1'b0;
                    st     <= S_PICK;
                end
                S_PICK: begin
                    if (!any) begin
                        done_q <= 1'b1;
                        ce_q   <= 1'b1;
                        st     <= S_IDLE;
                    end else if (idx == B_RB) begin
                        cur    <= idx;
                        wb_cnt <= '0;
                        st     <= S_RB;
                    end else if (zero_skip) begin
                        pend[idx] <= 1'b0;
                    end else begin
                        cur <= idx;
                        st  <= S_BYTE;
                    end
                end
                S_BYTE: if (tmr_done) begin
                    if (LEN_W'(cnt + 1'b1) == cur_total) begin
                        pend[cur] <= 1'b0;
                        cnt       <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                    st <= S_PICK;
                end
                S_RB: begin
                    if (wb_cnt != WBW'(T_WB)) begin
                        wb_cnt <= wb_cnt + 1'b1;
                    end else if (rb_sync[1]) begin
                        pend[cur] <= 1'b0;
                        st        <= S_PICK;
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    nseq_bus_timer #(
        .T_SETUP (T_SETUP),
        .T_PULSE (T_PULSE),
        .T_HOLD  (T_HOLD)
    ) u_tmr (
        .clk     (clk),
        .rst     (rst),
        .go      (go),
        .kind    (kind_of(idx)),
        .byte_in (tx_byte),
        .io_in   (io_in),
        .cle     (cle),
        .ale     (ale),
        .we_n    (we_n),
        .re_n    (re_n),
        .io_out  (io_out),
        .io_oe   (io_oe),
        .done    (tmr_done),
        .rd_vld  (rd_vld),
        .rd_byte (rd_byte)
    );

    nseq_page_buf #(.BYTES(BUF_BYTES), .IW(LEN_W)) u_buf (
        .clk     (clk),
        .h_we    (buf_we),
        .h_waddr (buf_waddr),
        .h_wdata (buf_wdata),
        .h_raddr (buf_raddr),
        .h_rdata (buf_rdata),
        .s_we    (rd_vld),
        .s_idx   (cnt),
        .s_wbyte (rd_byte),
        .s_rbyte (buf_rbyte)
    );

    assign done = done_q;
    assign busy = (st != S_IDLE);
    assign ce_n = ce_q;

    // R9: description cannot change once an operation is running
    p_start_ignored_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> $stable(d));

    // R6: a busy flash holds the wait state
    p_rb_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (st == S_RB && !rb_sync[1]) |=> (st == S_RB));

    // R8: done is sticky until cleared or restarted
    p_done_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (done && !done_clr && !(!busy && start)) |=> done);

    // R11: strobes only while the chip is selected
    p_ce_strobe_r11: assert property (@(posedge clk) disable iff (rst)
        (!we_n || !re_n) |-> !ce_n);
endmodule

// File: tb/tb_nand_seq.sv
module tb_nand_seq;
    localparam int T_SETUP = 2;
    localparam int T_PULSE = 3;
    localparam int T_HOLD  = 2;
    localparam int ID_LEN  = 5;
    localparam int RB_HOLD = 40;
    localparam int LEN_W   = 12;
    localparam int AW      = 10;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic             done_clr = 1'b0;
    logic [14:0]      code = '0;
    logic [15:0]      col_addr = '0;
    logic [23:0]      row_addr = '0;
    logic [LEN_W-1:0] xfer_len = '0;
    logic [7:0]       opc1 = '0, opc2 = '0, opc3 = '0;
    logic             done, busy;
    logic             buf_we = 1'b0;
    logic [AW-1:0]    buf_waddr = '0;
    logic [31:0]      buf_wdata = '0;
    logic [AW-1:0]    buf_raddr = '0;
    logic [31:0]      buf_rdata;
    logic             ce_n, cle, ale, we_n, re_n, io_oe;
    logic [7:0]       io_out;
    logic [7:0]       io_in = 8'h00;
    logic             rb_n = 1'b1;

    nand_seq #(
        .T_SETUP(T_SETUP), .T_PULSE(T_PULSE), .T_HOLD(T_HOLD),
        .T_WB(4), .ID_LEN(ID_LEN)
    ) dut (
        .clk(clk), .rst(rst), .start(start), .done_clr(done_clr),
        .code(code), .col_addr(col_addr), .row_addr(row_addr),
        .xfer_len(xfer_len), .opc1(opc1), .opc2(opc2), .opc3(opc3),
        .done(done), .busy(busy),
        .buf_we(buf_we), .buf_waddr(buf_waddr), .buf_wdata(buf_wdata),
        .buf_raddr(buf_raddr), .buf_rdata(buf_rdata),
        .ce_n(ce_n), .cle(cle), .ale(ale), .we_n(we_n), .re_n(re_n),
        .io_out(io_out), .io_oe(io_oe), .io_in(io_in), .rb_n(rb_n)
    );

    int checks = 0;
    int errors = 0;

    // ---------------- bus monitor (write-side events) ----------------
    int         ev_n = 0;
    logic [1:0] ev_k [256];
    logic [7:0] ev_b [256];
    time        t_wfall = 0, t_rfall = 0, t_ctl = 0;
    int         pw_bad = 0, su_bad = 0, rb_bad = 0;

    always @(posedge cle or posedge ale) t_ctl = $time;

    always @(negedge we_n) begin
        t_wfall = $time;
        if (!rb_n) rb_bad++;
        if ((cle || ale) && ($time - t_ctl != T_SETUP * 8)) su_bad++;
    end

    always @(posedge we_n) begin
        if (!rst) begin
            if ($time - t_wfall != T_PULSE * 8) pw_bad++;
            ev_k[ev_n[7:0]] = cle ? 2'd0 : (ale ? 2'd1 : 2'd2);
            ev_b[ev_n[7:0]] = io_out;
            ev_n++;
        end
    end

    // ---------------- flash model (read side) ----------------
    logic [7:0] fl [16];
    int         rd_total = 0;
    int         rd_base  = 0;

    always @(negedge re_n) begin
        t_rfall = $time;
        if (!rb_n) rb_bad++;
        io_in = fl[(rd_total - rd_base) & 15];
        rd_total++;
    end

    always @(posedge re_n) begin
        if (!rst && ($time - t_rfall != T_PULSE * 8)) pw_bad++;
    end

    // Busy line: goes low when the chosen opcode is latched
    logic       rb_en  = 1'b0;
    logic [7:0] rb_cmd = 8'h00;
    initial begin
        forever begin
            @(posedge we_n);
            if (rb_en && cle && io_out == rb_cmd) begin
                rb_n = 1'b0;
                repeat (RB_HOLD) @(negedge clk);
                rb_n = 1'b1;
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    logic [1:0] ek [32];
    logic [7:0] eb [32];
    int         exp_n;

    task automatic exp_clr();
        exp_n = 0;
    endtask

    task automatic exp_add(input logic [1:0] k, input logic [7:0] b);
        ek[exp_n] = k;
        eb[exp_n] = b;
        exp_n++;
    endtask

    task automatic chk_events(input string req, input int base);
        chk(ev_n - base == exp_n, {req, " event count"}, ev_n - base, exp_n);
        for (int i = 0; i < exp_n && i < ev_n - base; i++) begin
            chk({ev_k[(base + i) & 255], ev_b[(base + i) & 255]} == {ek[i], eb[i]},
                {req, " event"}, {ev_k[(base + i) & 255], ev_b[(base + i) & 255]},
                {ek[i], eb[i]});
        end
    endtask

    task automatic wait_done(input string req);
        int n = 0;
        while (!done && n < 5000) begin
            @(negedge clk);
            n++;
        end
        chk(done, {req, " done reached"}, done, 1);
    endtask

    task automatic launch(input logic [14:0] c, input logic [15:0] col,
                          input logic [23:0] row, input int len,
                          input logic [7:0] o1, input logic [7:0] o2,
                          input logic [7:0] o3);
        @(negedge clk);
        code = c; col_addr = col; row_addr = row; xfer_len = LEN_W'(len);
        opc1 = o1; opc2 = o2; opc3 = o3;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic host_wr(input int a, input logic [31:0] v);
        @(negedge clk);
        buf_we = 1'b1; buf_waddr = AW'(a); buf_wdata = v;
        @(negedge clk);
        buf_we = 1'b0;
    endtask

    task automatic host_rd(input int a, output logic [31:0] v);
        @(negedge clk);
        buf_raddr = AW'(a);
        @(negedge clk);
        v = buf_rdata;
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk({ce_n, we_n, re_n, cle, ale, io_oe, done, busy} == 8'b1110_0000,
            "R1 in reset", {ce_n, we_n, re_n, cle, ale, io_oe, done, busy}, 8'b1110_0000);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk({ce_n, we_n, re_n, cle, ale, io_oe, done, busy} == 8'b1110_0000,
            "R1 after reset", {ce_n, we_n, re_n, cle, ale, io_oe, done, busy}, 8'b1110_0000);
    endtask

    task automatic t_page_read();
        int base = ev_n;
        logic [31:0] w;
        fl[0] = 8'h11; fl[1] = 8'h22; fl[2] = 8'h33; fl[3] = 8'h44;
        fl[4] = 8'hA5; fl[5] = 8'h5A; fl[6] = 8'hC3; fl[7] = 8'h3C;
        rd_base = rd_total;
        rb_en = 1'b1; rb_cmd = 8'h30;
        launch(15'h7CE0, 16'h0102, 24'h00AB12, 8, 8'h00, 8'h30, 8'h00);
        wait_done("R6 read");
        rb_en = 1'b0;
        exp_clr();
        exp_add(0, 8'h00);
        exp_add(1, 8'h02); exp_add(1, 8'h01); exp_add(1, 8'h12); exp_add(1, 8'hAB);
        exp_add(0, 8'h30);
        chk_events("R2 R3 read order", base);
        chk(rd_total - rd_base == 8, "R5 read strobes", rd_total - rd_base, 8);
        host_rd(0, w); chk(w == 32'h11223344, "R5 word0", w, 32'h11223344);
        host_rd(1, w); chk(w == 32'hA55AC33C, "R5 word1", w, 32'hA55AC33C);
        chk(rb_bad == 0, "R6 no strobe while busy", rb_bad, 0);
    endtask

    task automatic t_program();
        int base;
        host_wr(0, 32'hDEADBEEF);
        host_wr(1, 32'h01234567);
        host_wr(2, 32'h89AB0000);
        base = ev_n;
        rd_base = rd_total;
        rb_en = 1'b1; rb_cmd = 8'h10;
        launch(15'h7FC0, 16'h0804, 24'h123456, 10, 8'h80, 8'h10, 8'h00);
        wait_done("R4 program");
        rb_en = 1'b0;
        exp_clr();
        exp_add(0, 8'h80);
        exp_add(1, 8'h04); exp_add(1, 8'h08);
        exp_add(1, 8'h56); exp_add(1, 8'h34); exp_add(1, 8'h12);
        exp_add(2, 8'hDE); exp_add(2, 8'hAD); exp_add(2, 8'hBE); exp_add(2, 8'hEF);
        exp_add(2, 8'h01); exp_add(2, 8'h23); exp_add(2, 8'h45); exp_add(2, 8'h67);
        exp_add(2, 8'h89); exp_add(2, 8'hAB);
        exp_add(0, 8'h10);
        chk_events("R4 R3 program", base);
        chk(rd_total == rd_base, "R4 no read strobes", rd_total - rd_base, 0);
    endtask

    task automatic t_skip();
        int base = ev_n;
        launch(15'h5010, 16'hA1B2, 24'h000000, 0, 8'h05, 8'h00, 8'hE0);
        wait_done("R2 skip");
        exp_clr();
        exp_add(0, 8'h05); exp_add(1, 8'hA1); exp_add(0, 8'hE0);
        chk_events("R2 R3 skipped cycles", base);
    endtask

    task automatic t_status_id();
        int base = ev_n;
        logic [31:0] w;
        fl[0] = 8'hE0;
        rd_base = rd_total;
        launch(15'h4008, 16'h0000, 24'h000000, 0, 8'h70, 8'h00, 8'h00);
        wait_done("R7 status");
        exp_clr(); exp_add(0, 8'h70);
        chk_events("R7 status cmd", base);
        chk(rd_total - rd_base == 1, "R7 status strobes", rd_total - rd_base, 1);
        host_rd(0, w); chk(w[31:24] == 8'hE0, "R7 status byte", w[31:24], 8'hE0);

        base = ev_n;
        fl[0] = 8'h2C; fl[1] = 8'hDA; fl[2] = 8'h90; fl[3] = 8'h95; fl[4] = 8'h06;
        rd_base = rd_total;
        launch(15'h6004, 16'h0000, 24'h000000, 0, 8'h90, 8'h00, 8'h00);
        wait_done("R7 id");
        exp_clr(); exp_add(0, 8'h90); exp_add(1, 8'h00);
        chk_events("R7 id cmd", base);
        chk(rd_total - rd_base == ID_LEN, "R7 id strobes", rd_total - rd_base, ID_LEN);
        host_rd(0, w); chk(w == 32'h2CDA9095, "R7 id word0", w, 32'h2CDA9095);
        host_rd(1, w); chk(w[31:24] == 8'h06, "R7 id word1", w[31:24], 8'h06);
    endtask

    task automatic t_zero_len();
        int base = ev_n;
        launch(15'h4180, 16'h0000, 24'h000000, 0, 8'h85, 8'h10, 8'h00);
        wait_done("R12 zero");
        exp_clr(); exp_add(0, 8'h85); exp_add(0, 8'h10);
        chk_events("R12 zero length", base);
    endtask

    task automatic t_busy_start();
        int base = ev_n;
        int n = 0;
        rb_en = 1'b1; rb_cmd = 8'hD0;
        launch(15'h40C0, 16'h0000, 24'h000000, 0, 8'h60, 8'hD0, 8'h00);
        chk(!done, "R8 start clears done", done, 0);
        while (rb_n && n < 2000) begin
            @(negedge clk);
            n++;
        end
        repeat (8) @(negedge clk);
        chk(busy && !ce_n, "R11 ce low in wait", {busy, ce_n}, 2'b10);
        @(negedge clk);
        code = 15'h4000; opc1 = 8'hFF; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done("R9 busy start");
        rb_en = 1'b0;
        exp_clr(); exp_add(0, 8'h60); exp_add(0, 8'hD0);
        chk_events("R9 ignored start", base);
        repeat (2) @(negedge clk);
        chk(!busy && ce_n, "R11 ce high after done", {busy, ce_n}, 2'b01);
        chk(rb_bad == 0, "R6 no strobe while busy", rb_bad, 0);
    endtask

    task automatic t_empty_and_sticky();
        int base = ev_n;
        launch(15'h0003, 16'h0000, 24'h000000, 0, 8'h00, 8'h00, 8'h00);
        wait_done("R8 empty");
        chk(ev_n == base, "R8 empty no events", ev_n - base, 0);
        repeat (20) @(negedge clk);
        chk(done, "R8 done sticky", done, 1);
        done_clr = 1'b1;
        @(negedge clk);
        done_clr = 1'b0;
        chk(!done, "R8 done cleared", done, 0);
    endtask

    // ---------------- main ----------------
    initial begin
        t_reset();
        t_page_read();
        t_program();
        t_skip();
        t_status_id();
        t_zero_len();
        t_busy_start();
        t_empty_and_sticky();
        chk(pw_bad == 0, "R10 strobe width", pw_bad, 0);
        chk(su_bad == 0, "R10 latch setup", su_bad, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule